// File: doc/BRIEF.md
# Latched Interrupt Controller with Master Enable

This block gathers interrupt requests from two external pins and from a set of internal timer events into one request latch per source. A latched source can reach the CPU only when its own enable bit is set and the master enable flip-flop is 1. Of the sources that qualify, the one with the highest fixed priority is offered to the CPU as a vector number, with a single request line.

When the CPU acknowledges a pending request, the controller treats it as accepted. It clears the latch of the winning source and the master enable, then pulses a save strobe that tells the CPU to store its program counter and flags. Software turns interrupts back on with one command. That command sets the master enable and clears, in the same cycle, every latch selected by a mask. The CPU core itself is not part of this block.

Source numbering follows priority. Source 0 is external pin 0 and has the highest priority. Sources 1 to NINT are the internal events in order: with the default NINT = 3 these are timer 1 overflow, timer 2 overflow and the interval timer. The last source, NINT+1, is external pin 1 and has the lowest priority.

Top module: `irq_latch_ctrl`

## Requirements
- R1: After reset, every latch, every enable bit, the master enable, `irq_o` and `save_o` are 0. Reset is asserted asynchronously and released two clock edges after `rst_n` rises.
- R2: `irq_o` is 1 exactly when the master enable is 1 and at least one source has both its latch and its enable bit at 1.
- R3: Each source is identified by a bit index, and the same index is used in `pend_o`, `en_data_i` and `clr_mask_i`. Bit 0 is pin 0, bits 1 to NINT are the internal events in the order of `tmr_evt_i`, and bit NINT+1 is pin 1. While `irq_o` is 1, `vec_o` gives the lowest index that is both latched and enabled.
- R4: A falling edge on an external pin passes through a two-stage synchronizer. The pin's latch is set on the third rising clock edge after the pin goes low. A rising edge does not set the latch, and neither does a pin that stays low.
- R5: An internal event input that is 1 during a cycle sets its latch at the end of that cycle.
- R6: The clear command sets the master enable and clears every latch whose mask bit is 1. Latches whose mask bit is 0 are left unchanged.
- R7: An enable write replaces the whole enable register and leaves every latch unchanged.
- R8: `ack_i` while `irq_o` is 1 is an acceptance. It clears the latch of the source given by `vec_o` and clears the master enable, and `save_o` is 1 for exactly the one following cycle.
- R9: `ack_i` while `irq_o` is 0 has no effect on the latches, on the master enable or on `save_o`.
- R10: If a latch is set and cleared in the same cycle, the set wins. If an acceptance and a clear command arrive in the same cycle, the master enable ends up 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ext_pin_i | input | 2 | External interrupt pins, idle high; bit 0 has the highest priority, bit 1 the lowest |
| tmr_evt_i | input | NINT | Internal event requests, one per timer source |
| en_wr_i | input | 1 | Write strobe for the enable register |
| en_data_i | input | NINT+2 | New per-source enable bits |
| clr_cmd_i | input | 1 | Command that sets the master enable and clears masked latches |
| clr_mask_i | input | NINT+2 | Latches to clear with the command |
| ack_i | input | 1 | Acknowledge from the CPU |
| irq_o | output | 1 | Request to the CPU |
| vec_o | output | clog2(NINT+2) | Index of the winning source |
| save_o | output | 1 | One-cycle strobe to save the program counter and flags |
| mie_o | output | 1 | Master enable state |
| pend_o | output | NINT+2 | Request latch state |

## Verification
The main sweep tries all 32 latch patterns against all 32 enable patterns. This separates gating by the enable bits (R2) from the choice of winner (R3), and the acknowledge that follows shows that only the winning latch is cleared. Because the pins are set by driving them low, and they are still low during the acknowledge, the same sweep checks that a pin held low does not set its latch again. The directed cases each cover one collision or no-effect rule: an acknowledge with no request, a partial-mask clear, an enable write on top of pending latches, a request that arrives together with its own acceptance, a clear command that arrives together with an acceptance, and a rising edge on a pin.

// File: rtl/irq_latch_pkg.sv
package irq_latch_pkg;
  // How the master enable changes in a given cycle
  typedef enum logic [1:0] {
    MIE_HOLD = 2'd0,
    MIE_SET  = 2'd1,
    MIE_CLR  = 2'd2
  } mie_op_e;
endpackage

// File: rtl/irq_rst_sync.sv
module irq_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/irq_edge_sync.sv
module irq_edge_sync #(
  parameter int unsigned W = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] pin_i,
  output logic [W-1:0] fall_o
);
  genvar g;
  generate
    for (g = 0; g < W; g++) begin : g_pin
      logic meta_q, sync_q, prev_q;
      logic meta_d, sync_d, prev_d;

      always_comb begin
        meta_d = pin_i[g];
        sync_d = meta_q;
        prev_d = sync_q;
      end

      // Idle level of the pins is high
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          meta_q <= 1'b1;
          sync_q <= 1'b1;
          prev_q <= 1'b1;
        end else begin
          meta_q <= meta_d;
          sync_q <= sync_d;
          prev_q <= prev_d;
        end
      end

      assign fall_o[g] = prev_q & ~sync_q;
    end
  endgenerate
endmodule

// File: rtl/irq_latch_bank.sv
module irq_latch_bank #(
  parameter int unsigned N = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] pend_o
);
  logic [N-1:0] pend_q;
  logic [N-1:0] pend_d;

  // A new request overrides a clear in the same cycle
  always_comb begin
    pend_d = (pend_q & ~clr_i) | set_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= '0;
    else        pend_q <= pend_d;
  end

  assign pend_o = pend_q;
endmodule

// File: rtl/irq_prio.sv
module irq_prio #(
  parameter int unsigned N  = 5,
  parameter int unsigned VW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  req_i,
  output logic          any_o,
  output logic [VW-1:0] idx_o
);
  // Lowest index wins: scan downward so the last hit is the smallest index
  always_comb begin
    idx_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req_i[i]) idx_o = VW'(i);
    end
    any_o = |req_i;
  end
endmodule

// File: rtl/irq_latch_ctrl.sv
module irq_latch_ctrl
  import irq_latch_pkg::*;
#(
  parameter int unsigned NINT = 3,
  localparam int unsigned NSRC = NINT + 2,
  localparam int unsigned VW   = $clog2(NSRC)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [1:0]      ext_pin_i,
  input  logic [NINT-1:0] tmr_evt_i,
  input  logic            en_wr_i,
  input  logic [NSRC-1:0] en_data_i,
  input  logic            clr_cmd_i,
  input  logic [NSRC-1:0] clr_mask_i,
  input  logic            ack_i,
  output logic            irq_o,
  output logic [VW-1:0]   vec_o,
  output logic            save_o,
  output logic            mie_o,
  output logic [NSRC-1:0] pend_o
);
  logic            rst_q_n;
  logic [1:0]      pin_fall;
  logic [NSRC-1:0] src_set;
  logic [NSRC-1:0] src_clr;
  logic [NSRC-1:0] pend_w;
  logic [NSRC-1:0] en_q, en_d;
  logic            mie_q, mie_d;
  logic            save_q, save_d;
  logic            any_w;
  logic [VW-1:0]   win_w;
  logic            accept;
  mie_op_e         mie_op;

  irq_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_q_n)
  );

  irq_edge_sync #(.W(2)) u_edge (
    .clk    (clk),
    .rst_n  (rst_q_n),
    .pin_i  (ext_pin_i),
    .fall_o (pin_fall)
  );

  // Source order: pin 0 first, then the internal events, then pin 1
  assign src_set = {pin_fall[1], tmr_evt_i, pin_fall[0]};

  irq_prio #(.N(NSRC), .VW(VW)) u_prio (
    .req_i (pend_w & en_q),
    .any_o (any_w),
    .idx_o (win_w)
  );

  assign irq_o  = mie_q & any_w;
  assign accept = ack_i & irq_o;

  always_comb begin
    src_clr = clr_cmd_i ? clr_mask_i : '0;
    if (accept) src_clr = src_clr | (NSRC'(1) << win_w);
  end

  irq_latch_bank #(.N(NSRC)) u_bank (
    .clk    (clk),
    .rst_n  (rst_q_n),
    .set_i  (src_set),
    .clr_i  (src_clr),
    .pend_o (pend_w)
  );

  // Master enable: an acceptance takes precedence over the clear command
  always_comb begin
    mie_op = MIE_HOLD;
    if (accept)         mie_op = MIE_CLR;
    else if (clr_cmd_i) mie_op = MIE_SET;
    case (mie_op)
      MIE_SET: mie_d = 1'b1;
      MIE_CLR: mie_d = 1'b0;
      default: mie_d = mie_q;
    endcase
    en_d   = en_wr_i ? en_data_i : en_q;
    save_d = accept;
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      en_q   <= '0;
      mie_q  <= 1'b0;
      save_q <= 1'b0;
    end else begin
      if (en_wr_i) en_q <= en_d;
      mie_q  <= mie_d;
      save_q <= save_d;
    end
  end

  assign vec_o  = win_w;
  assign save_o = save_q;
  assign mie_o  = mie_q;
  assign pend_o = pend_w;
endmodule

// File: rtl/irq_latch_chk.sv
module irq_latch_chk #(
  parameter int unsigned NSRC = 5,
  parameter int unsigned VW   = 3
) (
  input logic            clk,
  input logic            rst_n,
  input logic            ack_i,
  input logic            clr_cmd_i,
  input logic [NSRC-1:0] clr_mask_i,
  input logic            irq_o,
  input logic [VW-1:0]   vec_o,
  input logic            save_o,
  input logic            mie_o,
  input logic [NSRC-1:0] pend_o,
  input logic [NSRC-1:0] en_q,
  input logic [NSRC-1:0] src_set
);
  logic [NSRC-1:0] live;
  logic [NSRC-1:0] below;
  assign live  = pend_o & en_q;
  assign below = (NSRC'(1) << vec_o) - NSRC'(1);

  p_irq_needs_mie_r2: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> mie_o);

  p_winner_live_r3: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> (((live >> vec_o) & NSRC'(1)) != '0));

  p_winner_highest_r3: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> ((live & below) == '0));

  p_accept_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_i && irq_o) |=> (!mie_o && save_o));

  p_save_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
    save_o |-> $past(ack_i && irq_o));

  p_ack_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_i && !irq_o && !clr_cmd_i) |=> ($stable(mie_o) && !save_o));

  p_clr_cmd_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_cmd_i && !(ack_i && irq_o)) |=>
      (mie_o && ((pend_o & $past(clr_mask_i) & ~$past(src_set)) == '0)));

  p_set_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (src_set != '0) |=> ((pend_o & $past(src_set)) == $past(src_set)));
endmodule

bind irq_latch_ctrl irq_latch_chk #(.NSRC(NSRC), .VW(VW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_q_n),
  .ack_i      (ack_i),
  .clr_cmd_i  (clr_cmd_i),
  .clr_mask_i (clr_mask_i),
  .irq_o      (irq_o),
  .vec_o      (vec_o),
  .save_o     (save_o),
  .mie_o      (mie_o),
  .pend_o     (pend_o),
  .en_q       (en_q),
  .src_set    (src_set)
);

// File: tb/irq_latch_ctrl_bench.sv
module irq_latch_ctrl_bench;
  localparam int NINT = 3;
  localparam int NSRC = NINT + 2;
  localparam int VW   = $clog2(NSRC);

  logic            clk = 1'b0;
  logic            rst_n;
  logic [1:0]      ext_pin_i;
  logic [NINT-1:0] tmr_evt_i;
  logic            en_wr_i;
  logic [NSRC-1:0] en_data_i;
  logic            clr_cmd_i;
  logic [NSRC-1:0] clr_mask_i;
  logic            ack_i;
  logic            irq_o;
  logic [VW-1:0]   vec_o;
  logic            save_o;
  logic            mie_o;
  logic [NSRC-1:0] pend_o;

  int n_cmp = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  irq_latch_ctrl #(.NINT(NINT)) u_irq_latch_ctrl (
    .clk, .rst_n, .ext_pin_i, .tmr_evt_i, .en_wr_i, .en_data_i,
    .clr_cmd_i, .clr_mask_i, .ack_i, .irq_o, .vec_o, .save_o, .mie_o, .pend_o
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic quiet();
    tmr_evt_i  = '0;
    en_wr_i    = 1'b0;
    en_data_i  = '0;
    clr_cmd_i  = 1'b0;
    clr_mask_i = '0;
    ack_i      = 1'b0;
  endtask

  function automatic int lowest(input logic [NSRC-1:0] v);
    for (int i = NSRC - 1; i >= 0; i--) if (v[i]) lowest = i;
  endfunction

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    summary();
  end

  initial begin
    quiet();
    ext_pin_i = 2'b11;
    rst_n = 1'b0;
    tick(); tick(); tick();
    rst_n = 1'b1;
    tick(); tick(); tick(); tick();
    // R1: reset state
    chk("R1 pend", pend_o, 0);
    chk("R1 mie", mie_o, 0);
    chk("R1 irq", irq_o, 0);
    chk("R1 save", save_o, 0);

    // Sweep over every latch pattern against every enable pattern
    for (int pat = 0; pat < 32; pat++) begin
      for (int en = 0; en < 32; en++) begin
        logic [NSRC-1:0] p, e, live;
        p = NSRC'(pat);
        e = NSRC'(en);
        live = p & e;
        en_wr_i = 1'b1; en_data_i = e;
        clr_cmd_i = 1'b1; clr_mask_i = '1;
        tick();
        quiet();
        ext_pin_i = {~p[NSRC-1], ~p[0]};
        tmr_evt_i = p[NINT:1];
        tick();
        tmr_evt_i = '0;
        tick(); tick();
        chk("R4/R5 latched pattern", pend_o, p);
        chk("R2 irq gating", irq_o, live != 0);
        if (live != 0) begin
          int w;
          w = lowest(live);
          chk("R3 winner", vec_o, w);
          ack_i = 1'b1;
          tick();
          ack_i = 1'b0;
          chk("R8 winner cleared", pend_o, p & ~(NSRC'(1) << w));
          chk("R8 mie cleared", mie_o, 0);
          chk("R8 save pulse", save_o, 1);
          chk("R2 irq off with mie 0", irq_o, 0);
          tick();
          chk("R8 save one cycle", save_o, 0);
        end else begin
          chk("R6 mie set", mie_o, 1);
        end
        ext_pin_i = 2'b11;
        tick(); tick(); tick();
      end
    end

    // R9: ack with nothing offered
    en_wr_i = 1'b1; en_data_i = '0; clr_cmd_i = 1'b1; clr_mask_i = '1;
    tick(); quiet();
    tmr_evt_i = 3'b111; tick(); tmr_evt_i = '0;
    chk("R5 internal set", pend_o, 5'b01110);
    ack_i = 1'b1; tick(); ack_i = 1'b0;
    chk("R9 mie kept", mie_o, 1);
    chk("R9 pend kept", pend_o, 5'b01110);
    chk("R9 no save", save_o, 0);

    // R6: partial mask
    clr_cmd_i = 1'b1; clr_mask_i = 5'b00110; tick(); quiet();
    chk("R6 masked clear", pend_o, 5'b01000);
    chk("R6 mie", mie_o, 1);

    // R7: enable write leaves latches alone
    en_wr_i = 1'b1; en_data_i = '1; tick(); quiet();
    chk("R7 pend kept", pend_o, 5'b01000);
    chk("R7 irq", irq_o, 1);
    chk("R3 vec interval timer", vec_o, 3);

    // R10: new request in the cycle of its own acceptance
    ack_i = 1'b1; tmr_evt_i = 3'b100; tick(); quiet();
    chk("R10 set wins", pend_o, 5'b01000);
    chk("R10 mie", mie_o, 0);

    // R10: acceptance together with clear command
    clr_cmd_i = 1'b1; clr_mask_i = '0; tick(); quiet();
    chk("R6 mie re-set", mie_o, 1);
    ack_i = 1'b1; clr_cmd_i = 1'b1; clr_mask_i = '0; tick(); quiet();
    chk("R10 accept beats clear", mie_o, 0);
    chk("R10 latch cleared", pend_o, 0);

    // R4: rising edge does not latch
    ext_pin_i = 2'b10; tick(); tick(); tick();
    chk("R4 falling edge", pend_o, 5'b00001);
    clr_cmd_i = 1'b1; clr_mask_i = '1; tick(); quiet();
    ext_pin_i = 2'b11; tick(); tick(); tick(); tick();
    chk("R4 rising edge ignored", pend_o, 0);

    summary();
  end
endmodule